// File: doc/BRIEF.md
# Register-Programmed SPI Flash Transfer Engine

This block is the user-transfer half of an SPI master aimed at serial flash. Software fills a shared 64-byte buffer through 32-bit register writes. It sets the bit count, whether chip select stays asserted at the end, and the chip-select polarity. It then writes a start bit. The engine sends the buffer on MOSI, most significant bit of each byte first, and walks the bytes in ascending order. When capture is enabled, each bit sampled from MISO replaces the buffer bit that was just sent. When the last bit has been sampled, the engine raises a done flag. Software then reads the received bytes from the same buffer.

A longer flash command is split into chunks of up to 64 bytes. Setting the hold option on every chunk except the last keeps chip select asserted between chunks. SCK idles low. A separate clock generator supplies the pacing as a one-cycle `sck_tick` strobe. Each tick ends one half period of SCK.

The sequencer has three states:
- `ST_IDLE`: waiting for a start.
- `ST_LOW`: SCK is low and the current MOSI bit is being presented.
- `ST_HIGH`: SCK is high and the sampled MISO bit is held.

The sequencer has five transitions:
- `ST_IDLE` to `ST_LOW` on an accepted start.
- `ST_LOW` to `ST_HIGH` on a tick, which also samples MISO.
- `ST_HIGH` to `ST_LOW` on a tick when bits remain. This stores the captured bit and advances the bit index.
- `ST_HIGH` to `ST_IDLE` on a tick after the final bit. This sets done and applies the hold option to chip select.
- Any state to `ST_IDLE` on a software reset.

Top module: `sfx_engine`

## Requirements
- R1: Register map, with byte addresses. Bits not listed below read 0. The command word at 0x00 always reads 0. Each configuration bit reads back at its own position:
  - 0x08 bit 17: memory-map enable, stored only.
  - 0x1C bit 0: MISO capture enable.
  - 0x20 bits 25:17: bit count minus one.
  - 0x2C bit 30: chip-select hold.
  - 0x2C bit 23: chip select active-high.
  - 0x30 bit 30: mode (0 = master).
  - 0x30 bit 4: done flag.
- R2: The data window is 0x40 to 0x7C. Stream byte i lives in the word at 0x40 + 4*(i/4), at bits 8*(i%4)+7 down to 8*(i%4). Writes to the window are read back unchanged.
- R3: Writing 0x00 with bit 18 set, while idle and with mode bit 0, starts a transfer. Chip select is at its active level in the cycle after the write.
- R4: A transfer shifts (count field + 1) bits. Stream bit k is bit 7-(k%8) of byte k/8. While idle, MOSI is 0.
- R5: SCK is high between the first and second tick of each bit. The MISO level at the rising tick is written into the bit just sent, when capture is enabled. With capture disabled the buffer keeps its contents.
- R6: The done flag rises on the tick that ends the high phase of the final bit, and not before. Writing 0x30 with bit 4 = 0 clears it. Writing bit 4 = 1 leaves it unchanged.
- R7: At the end of a transfer, chip select stays active if the hold bit is 1. Otherwise it goes inactive in the same cycle that done rises.
- R8: Chip select is driven high when active and the active-high bit is 1. It is driven low when active and that bit is 0. The inactive level is the opposite one.
- R9: While a transfer runs, a start write is ignored, and so are writes to every register and to the buffer. The one exception is the software reset.
- R10: Writing 0x30 with bit 31 set does the following in one cycle: it aborts any transfer, clears done and every configuration field, and releases chip select. The buffer keeps its contents.
- R11: While the mode bit is 1, start writes are ignored.
- R12: The sequencer advances only on cycles where `sck_tick` is 1. Each SCK phase lasts until the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one word per cycle |
| bus_addr | input | 7 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sck_tick | input | 1 | Half-period strobe from the clock generator |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the flash |
| cs_pin | output | 1 | Chip select at the programmed polarity |

## Verification
A cycle-by-cycle model in the bench follows SCK, MOSI, chip select and the read port on every clock. It is driven with several transfer shapes:
- A short two-byte capture with a tick on every cycle. This exposes an off-by-one in the bit count, and leaves the next word untouched as a witness.
- A full 512-bit non-capturing transfer with sparse ticks and active-high hold. This separates the byte order from the bit order, and shows that the buffer is kept.
- A transfer frozen with no ticks at all. This isolates the tick gating.

Starts and writes issued mid-transfer, a software reset issued mid-transfer, and starts issued in the non-master mode each show whether the sequencer and the configuration can be disturbed.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] OFS_CMD   = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_USER  = 7'h1C;
    localparam logic [ADDR_W-1:0] OFS_USER1 = 7'h20;
    localparam logic [ADDR_W-1:0] OFS_USER4 = 7'h2C;
    localparam logic [ADDR_W-1:0] OFS_SLAVE = 7'h30;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 7'h40;

    localparam int BIT_START   = 18;
    localparam int BIT_MMAP    = 17;
    localparam int BIT_CAP_EN  = 0;
    localparam int LEN_LSB     = 17;
    localparam int BIT_HOLD    = 30;
    localparam int BIT_CS_HIGH = 23;
    localparam int BIT_SWRST   = 31;
    localparam int BIT_MODE    = 30;
    localparam int BIT_DONE    = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sfx_databuf.sv
module sfx_databuf #(
    parameter  int BYTES = 64,
    localparam int BITS  = BYTES * 8,
    localparam int WORDS = BYTES / 4,
    localparam int WA_W  = $clog2(WORDS),
    localparam int BA_W  = $clog2(BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [WA_W-1:0] bus_word,
    input  logic [31:0]     bus_wdata,
    input  logic [WA_W-1:0] rd_word,
    output logic [31:0]     rd_data,
    input  logic            bit_we,
    input  logic [BA_W-1:0] bit_idx,
    input  logic            bit_val,
    output logic            tx_bit
);

    logic [BITS-1:0] mem_q;
    logic [BA_W-1:0] pos;

    // stream bit k -> byte k/8, bit 7-(k%8)
    assign pos     = {bit_idx[BA_W-1:3], ~bit_idx[2:0]};
    assign tx_bit  = mem_q[pos];
    assign rd_data = mem_q[{rd_word, 5'b0} +: 32];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (bus_we) begin
            mem_q[{bus_word, 5'b0} +: 32] <= bus_wdata;
        end else if (bit_we) begin
            mem_q[pos] <= bit_val;
        end
    end

    // bus side is locked out while the shifter owns the buffer
    p_one_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bit_we));

endmodule

// File: rtl/sfx_seq.sv
module sfx_seq
    import sfx_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic             tick,
    input  logic [CNT_W-1:0] len,
    input  logic             hold,
    input  logic             miso,
    output logic             busy,
    output logic             sck,
    output logic             cs_act,
    output logic [CNT_W-1:0] bit_idx,
    output logic             cap_we,
    output logic             cap_bit,
    output logic             done_set
);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] idx_q;
    logic             rx_q, cs_q, last;

    assign last = (idx_q == len);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            rx_q    <= 1'b0;
            cs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clr)                            cs_q <= 1'b0;
            else if (state_q == ST_IDLE && start) begin
                cs_q  <= 1'b1;
                idx_q <= '0;
            end else if (done_set)              cs_q <= hold;
            if (!clr && state_q == ST_LOW && tick)
                rx_q <= miso;
            if (!clr && state_q == ST_HIGH && tick && !last)
                idx_q <= idx_q + CNT_W'(1);
        end
    end

    always_comb begin
        state_d  = state_q;
        cap_we   = 1'b0;
        done_set = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOW;
            ST_LOW:  if (tick)  state_d = ST_HIGH;
            ST_HIGH: if (tick) begin
                cap_we = 1'b1;
                if (last) begin
                    state_d  = ST_IDLE;
                    done_set = 1'b1;
                end else begin
                    state_d  = ST_LOW;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (clr) begin
            state_d  = ST_IDLE;
            cap_we   = 1'b0;
            done_set = 1'b0;
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign sck     = (state_q == ST_HIGH);
    assign cs_act  = cs_q;
    assign bit_idx = idx_q;
    assign cap_bit = rx_q;

    p_wait_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !tick && !clr |=> $stable(state_q) && $stable(idx_q));

    p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> idx_q <= len);

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_set && !hold |=> !cs_act);

endmodule

// File: rtl/sfx_engine.sv
module sfx_engine
    import sfx_pkg::*;
#(
    parameter  int BYTES = 64,
    localparam int CNT_W = $clog2(BYTES * 8),
    localparam int WA_W  = $clog2(BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              sck_tick,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              cs_pin
);

    logic             mmap_q, cap_en_q, hold_q, csh_q, mode_q, done_q;
    logic [CNT_W-1:0] len_q;
    logic             busy, cs_act, cap_we, cap_bit, done_set, tx_bit, sck_w;
    logic [CNT_W-1:0] bit_idx;
    logic [31:0]      word_rd;
    logic             sw_rst, wr_ok, in_data, start;
    logic             unused_bus_bits;

    assign unused_bus_bits = ^{bus_wdata, bus_addr};

    assign in_data = (bus_addr >= OFS_DATA);
    assign sw_rst  = bus_wr && bus_addr == OFS_SLAVE && bus_wdata[BIT_SWRST];
    assign wr_ok   = bus_wr && !busy && !sw_rst;
    assign start   = bus_wr && bus_addr == OFS_CMD && bus_wdata[BIT_START] && !mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || sw_rst) begin
            mmap_q <= 1'b0; cap_en_q <= 1'b0; hold_q <= 1'b0;
            csh_q  <= 1'b0; mode_q   <= 1'b0; done_q <= 1'b0;
            len_q  <= '0;
        end else begin
            if (done_set) done_q <= 1'b1;
            if (wr_ok) begin
                case (bus_addr)
                    OFS_CTRL:  mmap_q   <= bus_wdata[BIT_MMAP];
                    OFS_USER:  cap_en_q <= bus_wdata[BIT_CAP_EN];
                    OFS_USER1: len_q    <= bus_wdata[LEN_LSB +: CNT_W];
                    OFS_USER4: begin
                        hold_q <= bus_wdata[BIT_HOLD];
                        csh_q  <= bus_wdata[BIT_CS_HIGH];
                    end
                    OFS_SLAVE: begin
                        mode_q <= bus_wdata[BIT_MODE];
                        if (!bus_wdata[BIT_DONE]) done_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    sfx_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(sw_rst), .start(start),
        .tick(sck_tick), .len(len_q), .hold(hold_q), .miso(miso),
        .busy(busy), .sck(sck_w), .cs_act(cs_act), .bit_idx(bit_idx),
        .cap_we(cap_we), .cap_bit(cap_bit), .done_set(done_set)
    );

    sfx_databuf #(.BYTES(BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .bus_we(wr_ok && in_data), .bus_word(bus_addr[2 +: WA_W]),
        .bus_wdata(bus_wdata), .rd_word(bus_addr[2 +: WA_W]), .rd_data(word_rd),
        .bit_we(cap_we && cap_en_q), .bit_idx(bit_idx), .bit_val(cap_bit),
        .tx_bit(tx_bit)
    );

    assign sck    = sck_w;
    assign mosi   = busy && tx_bit;
    assign cs_pin = csh_q ? cs_act : !cs_act;

    always_comb begin
        bus_rdata = '0;
        if (in_data) begin
            bus_rdata = word_rd;
        end else begin
            case (bus_addr)
                OFS_CTRL:  bus_rdata[BIT_MMAP]           = mmap_q;
                OFS_USER:  bus_rdata[BIT_CAP_EN]         = cap_en_q;
                OFS_USER1: bus_rdata[LEN_LSB +: CNT_W]   = len_q;
                OFS_USER4: begin
                    bus_rdata[BIT_HOLD]    = hold_q;
                    bus_rdata[BIT_CS_HIGH] = csh_q;
                end
                OFS_SLAVE: begin
                    bus_rdata[BIT_MODE] = mode_q;
                    bus_rdata[BIT_DONE] = done_q;
                end
                default: ;
            endcase
        end
    end

    p_done_after_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(sck_w));

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !sw_rst |=> $stable(len_q) && $stable(hold_q) && $stable(csh_q));

    p_mode_blocks_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && mode_q |=> !busy);

endmodule

// File: tb/sfx_engine_bench.sv
module sfx_engine_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        sck_tick = 1'b0, miso = 1'b0;
    logic        sck, mosi, cs_pin;

    int total = 0, bad = 0;
    int tdiv = 1, tcnt = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit finished = 0;

    // behavioural model state
    int         m_st = 0, m_idx = 0, m_len = 0;
    logic       m_rx = 0, m_cs = 0, m_done = 0, m_mmap = 0, m_din = 0;
    logic       m_hold = 0, m_csh = 0, m_mode = 0;
    logic [7:0] mb [0:63];

    sfx_engine u_sfx_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_tick(sck_tick),
        .miso(miso), .sck(sck), .mosi(mosi), .cs_pin(cs_pin)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    function automatic logic [31:0] patw(input int w);
        return {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    endfunction

    function automatic logic [31:0] mrd(input logic [6:0] a);
        logic [31:0] r = '0;
        if (a >= 7'h40) begin
            for (int j = 0; j < 4; j++) r[8*j +: 8] = mb[4*int'(a[5:2]) + j];
        end else begin
            case (a)
                7'h08: r[17] = m_mmap;
                7'h1C: r[0]  = m_din;
                7'h20: r[25:17] = 9'(m_len);
                7'h2C: begin r[30] = m_hold; r[23] = m_csh; end
                7'h30: begin r[30] = m_mode; r[4] = m_done; end
                default: ;
            endcase
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // reference model, one update per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_len = 0; m_rx = 0; m_cs = 0; m_done = 0;
            m_mmap = 0; m_din = 0; m_hold = 0; m_csh = 0; m_mode = 0;
            for (int i = 0; i < 64; i++) mb[i] = 8'h00;
        end else begin
            automatic int busy = (m_st != 0);
            if (bus_wr && bus_addr == 7'h30 && bus_wdata[31]) begin
                m_st = 0; m_cs = 0; m_done = 0; m_mmap = 0; m_din = 0;
                m_hold = 0; m_csh = 0; m_mode = 0; m_len = 0;
            end else begin
                if (bus_wr && !busy) begin
                    if (bus_addr >= 7'h40) begin
                        for (int j = 0; j < 4; j++) mb[4*int'(bus_addr[5:2]) + j] = bus_wdata[8*j +: 8];
                    end else begin
                        case (bus_addr)
                            7'h08: m_mmap = bus_wdata[17];
                            7'h1C: m_din  = bus_wdata[0];
                            7'h20: m_len  = int'(bus_wdata[25:17]);
                            7'h2C: begin m_hold = bus_wdata[30]; m_csh = bus_wdata[23]; end
                            7'h30: begin m_mode = bus_wdata[30]; if (!bus_wdata[4]) m_done = 0; end
                            7'h00: if (bus_wdata[18] && !m_mode) begin m_st = 1; m_idx = 0; m_cs = 1; end
                            default: ;
                        endcase
                    end
                end
                if (busy && sck_tick) begin
                    if (m_st == 1) begin
                        m_rx = miso; m_st = 2;
                    end else begin
                        if (m_din) mb[m_idx/8][7 - m_idx%8] = m_rx;
                        if (m_idx == m_len) begin m_st = 0; m_done = 1; m_cs = m_hold; end
                        else begin m_idx++; m_st = 1; end
                    end
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R12 sck", 32'(sck), 32'(m_st == 2));
            chk("R4 mosi", 32'(mosi), 32'((m_st != 0) ? mb[m_idx/8][7 - m_idx%8] : 1'b0));
            chk("R8 cs", 32'(cs_pin), 32'(m_csh ? m_cs : !m_cs));
            chk(bus_addr >= 7'h40 ? "R2 rdata" : "R1 rdata", bus_rdata, mrd(bus_addr));
        end
    end

    // tick and miso stimulus
    always @(negedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso = lfsr[0];
        if (tdiv == 0) sck_tick = 1'b0;
        else begin
            sck_tick = (tcnt == 0);
            tcnt = (tcnt + 1) % tdiv;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rdchk(input logic [6:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata, exp);
        #1;
    endtask

    task automatic wait_idle();
        int guard = 0;
        do begin @(negedge clk); guard++; end while (m_st != 0 && guard < 20000);
        #1;
    endtask

    task automatic summary();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 180000);
        total++; bad++;
        $display("FAIL R4 watchdog act=running exp=finished");
        summary();
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(2);
        chk("R8 reset cs", 32'(cs_pin), 32'd1);
        chk("R4 reset sck", 32'(sck), 32'd0);
        rdchk(7'h30, 32'h0, "R1 reset slave");

        // R1 readback masks
        wr(7'h08, 32'hFFFF_FFFF); rdchk(7'h08, 32'h0002_0000, "R1 ctrl");
        wr(7'h1C, 32'hFFFF_FFFF); rdchk(7'h1C, 32'h0000_0001, "R1 user");
        wr(7'h20, 32'hFFFF_FFFF); rdchk(7'h20, 32'h03FE_0000, "R1 user1");
        wr(7'h2C, 32'hFFFF_FFFF); rdchk(7'h2C, 32'h4080_0000, "R1 user4");
        chk("R8 idle active-high", 32'(cs_pin), 32'd0);
        wr(7'h00, 32'hFFFB_FFFF); rdchk(7'h00, 32'h0, "R1 cmd");
        wr(7'h2C, 32'h0); wr(7'h08, 32'h0);

        // R11 mode bit blocks start
        wr(7'h30, 32'h4000_0010); rdchk(7'h30, 32'h4000_0000, "R11 slave");
        wr(7'h00, 32'h0004_0000); cyc(6);
        chk("R11 no start cs", 32'(cs_pin), 32'd1);
        wr(7'h30, 32'h0);

        // R2 buffer packing
        for (int w = 0; w < 16; w++) wr(7'h40 + 7'(4*w), patw(w));
        rdchk(7'h40, patw(0), "R2 word0");
        rdchk(7'h44, {pat(7), pat(6), pat(5), pat(4)}, "R2 byte order");
        rdchk(7'h7C, patw(15), "R2 word15");

        // two-byte capture, tick every cycle
        tdiv = 1;
        wr(7'h1C, 32'h1); wr(7'h20, 32'(15) << 17); wr(7'h2C, 32'h0);
        wr(7'h00, 32'h0004_0000);
        chk("R3 cs active", 32'(cs_pin), 32'd0);
        chk("R4 first bit msb", 32'(mosi), 32'(pat(0) >> 7));
        rdchk(7'h30, 32'h0, "R6 done low mid");
        wait_idle();
        chk("R7 released", 32'(cs_pin), 32'd1);
        rdchk(7'h30, 32'h10, "R6 done set");
        rdchk(7'h40, mrd(7'h40), "R5 captured");
        rdchk(7'h44, patw(1), "R4 length bound");
        wr(7'h30, 32'h10); rdchk(7'h30, 32'h10, "R6 keep");
        wr(7'h30, 32'h0);  rdchk(7'h30, 32'h0, "R6 clear");

        // full 512-bit, no capture, active-high hold, sparse ticks
        tdiv = 3;
        wr(7'h1C, 32'h0); wr(7'h20, 32'(511) << 17); wr(7'h2C, 32'h4080_0000);
        chk("R8 inactive high-pol", 32'(cs_pin), 32'd0);
        wr(7'h00, 32'h0004_0000);
        chk("R8 active high-pol", 32'(cs_pin), 32'd1);
        wait_idle();
        chk("R7 held", 32'(cs_pin), 32'd1);
        rdchk(7'h48, patw(2), "R5 kept w2");
        rdchk(7'h7C, patw(15), "R5 kept w15");

        // R9 writes during transfer ignored
        wr(7'h30, 32'h0); wr(7'h2C, 32'h0);
        tdiv = 5;
        wr(7'h1C, 32'h1); wr(7'h20, 32'(7) << 17);
        wr(7'h00, 32'h0004_0000);
        cyc(12);
        wr(7'h00, 32'h0004_0000);
        wr(7'h20, 32'(100) << 17);
        wr(7'h48, 32'hDEAD_BEEF);
        wait_idle();
        rdchk(7'h20, 32'(7) << 17, "R9 user1 frozen");
        rdchk(7'h48, patw(2), "R9 buffer frozen");

        // R12 no ticks, no progress
        tdiv = 0;
        wr(7'h20, 32'h0); wr(7'h00, 32'h0004_0000);
        cyc(20);
        chk("R12 frozen sck", 32'(sck), 32'd0);
        chk("R12 frozen cs", 32'(cs_pin), 32'd0);
        tdiv = 1;
        wait_idle();

        // R10 software reset mid-transfer
        tdiv = 2;
        wr(7'h2C, 32'h4000_0000); wr(7'h20, 32'(255) << 17);
        wr(7'h00, 32'h0004_0000);
        cyc(20);
        wr(7'h30, 32'h8000_0000);
        chk("R10 cs released", 32'(cs_pin), 32'd1);
        chk("R10 sck low", 32'(sck), 32'd0);
        rdchk(7'h20, 32'h0, "R10 user1");
        rdchk(7'h2C, 32'h0, "R10 user4");
        rdchk(7'h30, 32'h0, "R10 slave");
        rdchk(7'h7C, patw(15), "R10 buffer kept");
        cyc(4);
        summary();
    end

endmodule